// File: doc/BRIEF.md
# Store queue with commit-gated writeback

This block holds the stores that an out-of-order core has dispatched but not yet written to the data cache. It keeps them in a ring of slots. One slot always stays empty, so that a full ring can be told apart from an empty one. Three pointers walk the ring. The tail is where a new store is written. The writeback pointer is the oldest store that has not yet been sent to the cache. The head is the oldest store still resident. A store may be sent to the cache only after the commit stage has declared it eligible. The commit stage does this with a "youngest committed" sequence number. Eligible stores leave in program order, at most one per cycle, over a valid/ready request channel.

An ordinary store counts as complete once the cache accepts it. A conditional store counts as complete only when a response names its slot. A store of size zero completes at the writeback pointer without a request. The head retires every completed store it reaches, in one cycle. A squash removes the youngest stores that are not yet eligible. A load may register that it waits on a given store. The block then pulses a replay request with that load's position once the store has been sent or skipped.

The writeback pointer is driven by a two-state machine.
- `WB_RUN` is the normal state. It presents the store at the writeback pointer, or skips it when its size is zero.
- When a presented request is refused, `WB_RUN` goes to `WB_BLOCKED`.
- `WB_BLOCKED` keeps presenting the same request.
- `WB_BLOCKED` returns to `WB_RUN` in the cycle the cache accepts the request.

Top module: `sq_store_queue`

## Requirements
- R1: After reset the queue is empty, `sq_count` is 0, `sq_full` is 0, `head_idx` is 0, and `req_valid`, `wb_blocked` and `replay_valid` are 0.
- R2: An allocation writes the slot shown on `alloc_idx`. The queue holds at most DEPTH-1 stores, and `sq_full` is 1 exactly when it does. An allocation while full is ignored. `lsq_free` equals the smaller of `lq_free_slots` and (DEPTH - `sq_count`), minus one.
- R3: No cache request is made for a store that commit has not yet marked eligible.
- R4: Commit scans from the head. It marks each store whose sequence number is at or below `commit_seq`. It stops at the first store that is neither eligible nor at or below `commit_seq`, and stores behind that point stay ineligible even if their number is lower.
- R5: Eligible stores are requested in program order, one per cycle. `req_idx` and `req_addr` name the store at the writeback pointer. A request appears in the cycle after the commit that made it eligible.
- R6: An eligible store with `alloc_size` 0 produces no request. It completes as it is passed, and the next store is requested one cycle later.
- R7: A refused request sets `wb_blocked`. The same request (`req_valid`, `req_idx`) is held until `req_ready` is seen, and then `wb_blocked` clears.
- R8: An ordinary store completes when accepted. A store allocated with `alloc_cond` = 1 completes only when `resp_valid` is given with its slot on `resp_idx`.
- R9: In each cycle the head retires the whole run of completed stores that starts at the head, so `sq_count` falls by that run's length. An incomplete store at the head blocks every completed store behind it.
- R10: A squash removes, starting at the tail, the stores whose sequence number is above `squash_seq`. It stops at the first eligible store. In a squash cycle, allocation and commit are ignored.
- R11: After `stall_valid` registers a load position against a store sequence number, `replay_valid` pulses for one cycle with that position on `replay_lq`. The pulse comes in the cycle after that store is accepted by the cache or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Byte count; 0 means no data to write |
| alloc_cond | input | 1 | 1 for a conditional store that waits for a response |
| alloc_idx | output | IW | Slot the next allocation uses |
| sq_count | output | CW | Stores resident |
| sq_full | output | 1 | No room for another store |
| head_idx | output | IW | Oldest resident slot |
| lq_free_slots | input | LQ_W+1 | Free slots of the load queue, sentinel included |
| lsq_free | output | LQ_W+1 | Free entries reported upstream |
| commit_valid | input | 1 | Commit update this cycle |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash this cycle |
| squash_seq | input | SEQ_W | Stores above this number are discarded |
| req_valid | output | 1 | Cache write request present |
| req_ready | input | 1 | Cache takes the request |
| req_idx | output | IW | Slot of the requested store |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_size | output | SIZE_W | Request byte count |
| req_cond | output | 1 | Request is a conditional store |
| resp_valid | input | 1 | Response for a conditional store |
| resp_idx | input | IW | Slot the response belongs to |
| wb_blocked | output | 1 | Writeback machine is in WB_BLOCKED |
| stall_valid | input | 1 | Register a load waiting on a store |
| stall_seq | input | SEQ_W | Sequence number of the store waited on |
| stall_lq | input | LQ_W | Load queue position to replay |
| replay_valid | output | 1 | Replay request pulse |
| replay_lq | output | LQ_W | Load position to replay |

## Verification
The assertions assume a well-behaved cache and core around the block.
- `resp_valid` names only a resident conditional store that has been sent and is not yet complete.
- `lq_free_slots` is never 0.
- Sequence numbers grow in program order within one queue lifetime, except where a test builds an out-of-order commit scan on purpose.

The directed stimulus keeps to these rules in every scenario. It drains the queue between scenarios, so sequence comparisons never meet stale entries. It drops `req_ready` only in the scenarios that test blocking and squash, and it raises `req_ready` again before draining.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [0:0] {
        WB_RUN     = 1'b0,
        WB_BLOCKED = 1'b1
    } wb_state_e;

    // distance walking forward from b to a on a ring of the given size
    function automatic int ring_off(input int a, input int b, input int depth);
        return (a - b + depth) % depth;
    endfunction

endpackage

// File: rtl/sq_run_scan.sv
// Length of the run of set bits met when walking the ring from a start slot,
// forward (start, start+1, ...) or backward (start-1, start-2, ...),
// limited to the number of resident entries.
module sq_run_scan #(
    parameter int DEPTH    = 8,
    parameter int IW       = 3,
    parameter int CW       = 4,
    parameter bit BACKWARD = 1'b0
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [IW-1:0]    start,
    input  logic [CW-1:0]    limit,
    output logic [CW-1:0]    len
);

    logic [DEPTH-1:0] ord_hit;

    for (genvar k = 0; k < DEPTH; k++) begin : g_ord
        if (BACKWARD) begin : g_bwd
            assign ord_hit[k] = hit[IW'((int'(start) + 2 * DEPTH - 1 - k) % DEPTH)];
        end else begin : g_fwd
            assign ord_hit[k] = hit[IW'((int'(start) + k) % DEPTH)];
        end
    end

    always_comb begin
        logic go;
        go  = 1'b1;
        len = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (go && (k < int'(limit)) && ord_hit[k]) begin
                len = CW'(k + 1);
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3,
    parameter int LQ_W   = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int FW    = LQ_W + 1,
    localparam int CAP   = DEPTH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic              alloc_cond,
    output logic [IW-1:0]     alloc_idx,
    output logic [CW-1:0]     sq_count,
    output logic              sq_full,
    output logic [IW-1:0]     head_idx,
    input  logic [FW-1:0]     lq_free_slots,
    output logic [FW-1:0]     lsq_free,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IW-1:0]     req_idx,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [SIZE_W-1:0] req_size,
    output logic              req_cond,
    input  logic              resp_valid,
    input  logic [IW-1:0]     resp_idx,
    output logic              wb_blocked,
    input  logic              stall_valid,
    input  logic [SEQ_W-1:0]  stall_seq,
    input  logic [LQ_W-1:0]   stall_lq,
    output logic              replay_valid,
    output logic [LQ_W-1:0]   replay_lq
);

    // ---------------- storage ----------------
    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [SIZE_W-1:0] size_q [DEPTH];
    logic [DEPTH-1:0]  cond_q, valid_q, elig_q, done_q;

    logic [IW-1:0] head_q, wb_q, tail_q;
    logic [CW-1:0] count_q;
    wb_state_e     state_q, state_d;

    logic              stall_on_q;
    logic [SEQ_W-1:0]  stall_seq_q;
    logic [LQ_W-1:0]   stall_lq_q;
    logic              replay_q;
    logic [LQ_W-1:0]   replay_lq_q;

    // ---------------- scans ----------------
    logic [DEPTH-1:0] commit_hit, squash_hit;
    logic [CW-1:0]    commit_len, squash_len, retire_len;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            commit_hit[i] = elig_q[i] || (seq_q[i] <= commit_seq);
            squash_hit[i] = !elig_q[i] && (seq_q[i] > squash_seq);
        end
    end

    sq_run_scan #(.DEPTH(DEPTH), .IW(IW), .CW(CW), .BACKWARD(1'b0)) u_commit_scan (
        .hit(commit_hit), .start(head_q), .limit(count_q), .len(commit_len)
    );

    sq_run_scan #(.DEPTH(DEPTH), .IW(IW), .CW(CW), .BACKWARD(1'b1)) u_squash_scan (
        .hit(squash_hit), .start(tail_q), .limit(count_q), .len(squash_len)
    );

    sq_run_scan #(.DEPTH(DEPTH), .IW(IW), .CW(CW), .BACKWARD(1'b0)) u_retire_scan (
        .hit(done_q), .start(head_q), .limit(count_q), .len(retire_len)
    );

    // ---------------- writeback machine ----------------
    logic cur_ok, cur_zero, skip, accept, fire_replay;
    logic do_alloc, do_commit;

    assign cur_ok    = (wb_q != tail_q) && elig_q[wb_q];
    assign cur_zero  = (size_q[wb_q] == '0);
    assign do_alloc  = alloc_valid && !squash_valid && (int'(count_q) < CAP);
    assign do_commit = commit_valid && !squash_valid;

    // output process
    always_comb begin
        req_valid = 1'b0;
        skip      = 1'b0;
        unique case (state_q)
            WB_RUN: begin
                req_valid = cur_ok && !cur_zero;
                skip      = cur_ok && cur_zero;
            end
            WB_BLOCKED: begin
                req_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign accept      = req_valid && req_ready;
    assign fire_replay = (skip || accept) && stall_on_q && (seq_q[wb_q] == stall_seq_q);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_RUN:     if (req_valid && !req_ready) state_d = WB_BLOCKED;
            WB_BLOCKED: if (req_ready)               state_d = WB_RUN;
            default:                                 state_d = WB_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WB_RUN;
        else        state_q <= state_d;
    end

    // ---------------- queue state ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q      <= '0;
            wb_q        <= '0;
            tail_q      <= '0;
            count_q     <= '0;
            valid_q     <= '0;
            elig_q      <= '0;
            done_q      <= '0;
            cond_q      <= '0;
            stall_on_q  <= 1'b0;
            stall_seq_q <= '0;
            stall_lq_q  <= '0;
            replay_q    <= 1'b0;
            replay_lq_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (do_commit && (ring_off(i, int'(head_q), DEPTH) < int'(commit_len)))
                    elig_q[i] <= 1'b1;
                if (squash_valid &&
                    (ring_off(int'(tail_q) - 1, i, DEPTH) < int'(squash_len))) begin
                    valid_q[i] <= 1'b0;
                    elig_q[i]  <= 1'b0;
                    done_q[i]  <= 1'b0;
                end
                if (ring_off(i, int'(head_q), DEPTH) < int'(retire_len)) begin
                    valid_q[i] <= 1'b0;
                    elig_q[i]  <= 1'b0;
                    done_q[i]  <= 1'b0;
                end
            end

            if (skip || (accept && !cond_q[wb_q])) done_q[wb_q] <= 1'b1;
            if (resp_valid)                        done_q[resp_idx] <= 1'b1;
            if (skip || accept)                    wb_q <= IW'((int'(wb_q) + 1) % DEPTH);

            if (do_alloc) begin
                valid_q[tail_q] <= 1'b1;
                elig_q[tail_q]  <= 1'b0;
                done_q[tail_q]  <= 1'b0;
                cond_q[tail_q]  <= alloc_cond;
            end

            head_q <= IW'((int'(head_q) + int'(retire_len)) % DEPTH);
            if (squash_valid)
                tail_q <= IW'((int'(tail_q) + DEPTH - int'(squash_len)) % DEPTH);
            else if (do_alloc)
                tail_q <= IW'((int'(tail_q) + 1) % DEPTH);
            count_q <= CW'(int'(count_q) - int'(retire_len)
                           - (squash_valid ? int'(squash_len) : 0)
                           + (do_alloc ? 1 : 0));

            replay_q    <= fire_replay;
            replay_lq_q <= stall_lq_q;
            if (fire_replay) stall_on_q <= 1'b0;
            if (stall_valid) begin
                stall_on_q  <= 1'b1;
                stall_seq_q <= stall_seq;
                stall_lq_q  <= stall_lq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_alloc) begin
            seq_q[tail_q]  <= alloc_seq;
            addr_q[tail_q] <= alloc_addr;
            data_q[tail_q] <= alloc_data;
            size_q[tail_q] <= alloc_size;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        int sq_slots;
        int lq_slots;
        sq_slots = DEPTH - int'(count_q);
        lq_slots = int'(lq_free_slots);
        lsq_free = FW'(((lq_slots < sq_slots) ? lq_slots : sq_slots) - 1);
    end

    assign alloc_idx    = tail_q;
    assign sq_count     = count_q;
    assign sq_full      = (int'(count_q) == CAP);
    assign head_idx     = head_q;
    assign req_idx      = wb_q;
    assign req_addr     = addr_q[wb_q];
    assign req_data     = data_q[wb_q];
    assign req_size     = size_q[wb_q];
    assign req_cond     = cond_q[wb_q];
    assign wb_blocked   = (state_q == WB_BLOCKED);
    assign replay_valid = replay_q;
    assign replay_lq    = replay_lq_q;

    // ---------------- assertions ----------------
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= CAP);

    p_req_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (valid_q[req_idx] && elig_q[req_idx]));

    p_hold_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_idx)));

    p_resp_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (valid_q[resp_idx] && cond_q[resp_idx] && !done_q[resp_idx]));

    p_retire_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_q) |-> $past(done_q[head_q]));

endmodule

// File: tb/sq_store_queue_bench.sv
module sq_store_queue_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [7:0]  alloc_seq = '0;
    logic [15:0] alloc_addr = '0;
    logic [31:0] alloc_data = '0;
    logic [2:0]  alloc_size = '0;
    logic        alloc_cond = 1'b0;
    logic [2:0]  alloc_idx;
    logic [3:0]  sq_count;
    logic        sq_full;
    logic [2:0]  head_idx;
    logic [4:0]  lq_free_slots = 5'd20;
    logic [4:0]  lsq_free;
    logic        commit_valid = 1'b0;
    logic [7:0]  commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [7:0]  squash_seq = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [2:0]  req_idx;
    logic [15:0] req_addr;
    logic [31:0] req_data;
    logic [2:0]  req_size;
    logic        req_cond;
    logic        resp_valid = 1'b0;
    logic [2:0]  resp_idx = '0;
    logic        wb_blocked;
    logic        stall_valid = 1'b0;
    logic [7:0]  stall_seq = '0;
    logic [3:0]  stall_lq = '0;
    logic        replay_valid;
    logic [3:0]  replay_lq;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sq_store_queue u_sq_store_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_size(alloc_size), .alloc_cond(alloc_cond),
        .alloc_idx(alloc_idx), .sq_count(sq_count), .sq_full(sq_full),
        .head_idx(head_idx), .lq_free_slots(lq_free_slots), .lsq_free(lsq_free),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
        .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
        .req_cond(req_cond), .resp_valid(resp_valid), .resp_idx(resp_idx),
        .wb_blocked(wb_blocked), .stall_valid(stall_valid), .stall_seq(stall_seq),
        .stall_lq(stall_lq), .replay_valid(replay_valid), .replay_lq(replay_lq)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] s, input logic [15:0] a, input logic [2:0] sz,
                       input logic c, output logic [2:0] idx);
        idx         = alloc_idx;
        alloc_valid = 1'b1;
        alloc_seq   = s;
        alloc_addr  = a;
        alloc_data  = {16'hD0, a};
        alloc_size  = sz;
        alloc_cond  = c;
        cyc();
        alloc_valid = 1'b0;
        alloc_cond  = 1'b0;
    endtask

    task automatic commit(input logic [7:0] s);
        commit_valid = 1'b1;
        commit_seq   = s;
        cyc();
        commit_valid = 1'b0;
    endtask

    task automatic squash(input logic [7:0] s);
        squash_valid = 1'b1;
        squash_seq   = s;
        cyc();
        squash_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", int'(sq_count), 0);
        check("R1 full", int'(sq_full), 0);
        check("R1 head", int'(head_idx), 0);
        check("R1 req_valid", int'(req_valid), 0);
        check("R1 blocked", int'(wb_blocked), 0);
        check("R1 replay", int'(replay_valid), 0);
        check("R2 lsq_free empty", int'(lsq_free), 7);
    endtask

    task automatic t_order();
        logic [2:0] i0, i1, i2;
        put(8'd10, 16'h0100, 3'd4, 1'b0, i0);
        put(8'd11, 16'h0104, 3'd4, 1'b0, i1);
        put(8'd12, 16'h0108, 3'd4, 1'b0, i2);
        cyc(2);
        check("R3 no request before commit", int'(req_valid), 0);
        commit(8'd11);
        check("R5 first req valid", int'(req_valid), 1);
        check("R5 first req idx", int'(req_idx), int'(i0));
        check("R5 first req addr", int'(req_addr), 16'h0100);
        cyc();
        check("R5 second req idx", int'(req_idx), int'(i1));
        check("R5 second req addr", int'(req_addr), 16'h0104);
        cyc();
        check("R3 uncommitted store held", int'(req_valid), 0);
        cyc(3);
        check("R9 count after retire", int'(sq_count), 1);
        check("R9 head at third store", int'(head_idx), int'(i2));
        commit(8'd12);
        cyc(4);
        check("R9 drained", int'(sq_count), 0);
    endtask

    task automatic t_commit_stop();
        logic [2:0] a, b, c;
        put(8'd30, 16'h0300, 3'd4, 1'b0, a);
        put(8'd40, 16'h0304, 3'd4, 1'b0, b);
        put(8'd35, 16'h0308, 3'd4, 1'b0, c);
        commit(8'd36);
        check("R4 older store requested", int'(req_idx), int'(a));
        cyc();
        check("R4 scan stopped at younger store", int'(req_valid), 0);
        cyc(3);
        check("R4 two stores still waiting", int'(sq_count), 2);
        commit(8'd40);
        check("R4 second commit idx b", int'(req_idx), int'(b));
        cyc();
        check("R4 second commit idx c", int'(req_idx), int'(c));
        cyc(4);
        check("R4 drained", int'(sq_count), 0);
    endtask

    task automatic t_zero();
        logic [2:0] z, n;
        put(8'd80, 16'h0800, 3'd0, 1'b0, z);
        put(8'd81, 16'h0804, 3'd4, 1'b0, n);
        commit(8'd81);
        check("R6 zero-size makes no request", int'(req_valid), 0);
        cyc();
        check("R6 next store requested", int'(req_valid), 1);
        check("R6 next store idx", int'(req_idx), int'(n));
        cyc(4);
        check("R6 both completed", int'(sq_count), 0);
    endtask

    task automatic t_block();
        logic [2:0] s;
        req_ready = 1'b0;
        put(8'd50, 16'h0500, 3'd4, 1'b0, s);
        commit(8'd50);
        check("R7 request up", int'(req_valid), 1);
        check("R7 not yet blocked", int'(wb_blocked), 0);
        cyc();
        check("R7 blocked after refusal", int'(wb_blocked), 1);
        check("R7 request held", int'(req_valid), 1);
        check("R7 same idx", int'(req_idx), int'(s));
        cyc();
        check("R7 still blocked", int'(wb_blocked), 1);
        req_ready = 1'b1;
        cyc();
        check("R7 blocked cleared", int'(wb_blocked), 0);
        check("R7 no further request", int'(req_valid), 0);
        cyc(3);
        check("R7 drained", int'(sq_count), 0);
    endtask

    task automatic t_cond();
        logic [2:0] c, o, h0;
        h0 = head_idx;
        put(8'd60, 16'h0600, 3'd4, 1'b1, c);
        put(8'd61, 16'h0604, 3'd4, 1'b0, o);
        commit(8'd61);
        check("R8 cond request flag", int'(req_cond), 1);
        cyc(5);
        check("R8 conditional waits for response", int'(sq_count), 2);
        check("R9 head blocked by incomplete", int'(head_idx), int'(h0));
        resp_valid = 1'b1;
        resp_idx   = c;
        cyc();
        resp_valid = 1'b0;
        cyc();
        check("R9 run retired in one cycle", int'(sq_count), 0);
        check("R9 head jumped two", int'(head_idx), (int'(h0) + 2) % 8);
    endtask

    task automatic t_squash();
        logic [2:0] a, b, c, d;
        put(8'd13, 16'h0130, 3'd4, 1'b0, a);
        put(8'd14, 16'h0134, 3'd4, 1'b0, b);
        put(8'd15, 16'h0138, 3'd4, 1'b0, c);
        alloc_valid = 1'b1;
        alloc_seq   = 8'd16;
        alloc_size  = 3'd4;
        squash(8'd13);
        alloc_valid = 1'b0;
        check("R10 younger removed, alloc ignored", int'(sq_count), 1);
        check("R10 tail rewound", int'(alloc_idx), (int'(a) + 1) % 8);
        commit(8'd13);
        cyc(4);
        check("R10 survivor drained", int'(sq_count), 0);
        req_ready = 1'b0;
        put(8'd90, 16'h0900, 3'd4, 1'b0, d);
        put(8'd91, 16'h0904, 3'd4, 1'b0, a);
        commit(8'd90);
        cyc();
        squash(8'd85);
        check("R10 stops at eligible store", int'(sq_count), 1);
        check("R10 eligible request kept", int'(req_idx), int'(d));
        req_ready = 1'b1;
        cyc(4);
        check("R10 eligible store written", int'(sq_count), 0);
    endtask

    task automatic t_full();
        logic [2:0] x;
        lq_free_slots = 5'd3;
        cyc();
        check("R2 lsq_free limited by load side", int'(lsq_free), 2);
        lq_free_slots = 5'd20;
        for (int k = 0; k < 7; k++) put(8'(100 + k), 16'(16'h1000 + 4 * k), 3'd4, 1'b0, x);
        check("R2 full at capacity", int'(sq_full), 1);
        check("R2 count at capacity", int'(sq_count), 7);
        check("R2 lsq_free zero", int'(lsq_free), 0);
        put(8'd107, 16'h2000, 3'd4, 1'b0, x);
        check("R2 alloc while full ignored", int'(sq_count), 7);
        squash(8'd99);
        check("R2 emptied by squash", int'(sq_count), 0);
        check("R2 full cleared", int'(sq_full), 0);
    endtask

    task automatic t_replay();
        logic [2:0] s;
        put(8'd70, 16'h0700, 3'd4, 1'b0, s);
        stall_valid = 1'b1;
        stall_seq   = 8'd70;
        stall_lq    = 4'd5;
        cyc();
        stall_valid = 1'b0;
        commit(8'd70);
        check("R11 no replay before send", int'(replay_valid), 0);
        cyc();
        check("R11 replay after send", int'(replay_valid), 1);
        check("R11 replay load position", int'(replay_lq), 5);
        cyc();
        check("R11 replay is one pulse", int'(replay_valid), 0);
        cyc(3);
        check("R11 drained", int'(sq_count), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_order();
        t_commit_stop();
        t_zero();
        t_block();
        t_cond();
        t_squash();
        t_full();
        t_replay();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule